// File: doc/BRIEF.md
# Two-Way Byte Mailbox With Interrupt Semaphores

This block links a host processor bus to the bus of a sound-board processor through one byte in each direction. A host write leaves a command byte for the sound processor and raises that processor's interrupt. The sound processor answers by writing a reply byte, which raises a fast interrupt on the host. Each interrupt is held by a semaphore flip-flop. The semaphore drops only when the receiving side reads the matching data port.

On the host side the block decodes a two-register window from five address bits and an active-low enable. The data register carries the two bytes. The control register has a different meaning for each direction. A write of any value to it fires a fixed-length reset pulse at the sound processor. A read of it returns the reply semaphore on the top data bit and leaves the other bits undriven. Because the host data bus may be undriven, the read data comes with a per-bit drive-enable vector, and the chip's pad logic resolves it.

All strobes are one clock wide. Read data is combinational while a strobe is high. Latch loads, semaphore changes and reset triggers take effect at the clock edge that ends the strobe cycle.

Top module: `mbox_bridge`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both semaphores are clear (`host_firq_n` = 1, `snd_irq_n` = 1), `snd_cpu_rst` = 0, `host_rdata_oe` = 0 and both latches hold 0.
- R2: The host window is hit only when `host_sel_n` = 0, `host_addr[4:2]` = 3'b111 and `host_addr[1]` = 0. For any other address or enable, including `host_addr[4:1]` = 4'b1111 with the enable low, `host_rdata_oe` stays 0 and a host write changes neither latch, neither semaphore nor `snd_cpu_rst`.
- R3: A host write hitting the window with `host_addr[0]` = 0 loads `host_wdata` into the command latch. From the next cycle it drives `snd_irq_n` low.
- R4: A host read hitting the window with `host_addr[0]` = 0 returns the reply latch on `host_rdata` in the same cycle with `host_rdata_oe` = 8'hFF. It clears the reply semaphore, so `host_firq_n` is high from the next cycle.
- R5: A host write hitting the window with `host_addr[0]` = 1, whatever the data, holds `snd_cpu_rst` high for exactly 4 cycles starting the next cycle. A further such write during the pulse restarts the 4-cycle count. The pulse leaves both latches and both semaphores unchanged.
- R6: A host read hitting the window with `host_addr[0]` = 1 returns the reply semaphore (1 = reply pending) on `host_rdata[7]`, with `host_rdata_oe` = 8'h80. It does not clear the semaphore.
- R7: `snd_rdata` always shows the command latch. A `snd_cmd_rd` strobe clears the command semaphore, so `snd_irq_n` is high from the next cycle.
- R8: A `snd_rply_wr` strobe loads `snd_wdata` into the reply latch. From the next cycle it drives `host_firq_n` low.
- R9: When a semaphore is set and cleared in the same cycle, the set wins: the semaphore stays set and the latch takes the new byte. The read in that cycle returns the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 5 | Host address bits 4..0 |
| host_sel_n | input | 1 | Active-low host I/O enable |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rdata_oe | output | 8 | Per-bit drive enable for host_rdata |
| host_firq_n | output | 1 | Active-low fast interrupt to the host (reply pending) |
| snd_cmd_rd | input | 1 | Sound-side command read strobe |
| snd_rply_wr | input | 1 | Sound-side reply write strobe |
| snd_wdata | input | 8 | Sound-side reply data |
| snd_rdata | output | 8 | Command latch contents |
| snd_irq_n | output | 1 | Active-low interrupt to the sound processor (command pending) |
| snd_cpu_rst | output | 1 | Active-high reset pulse to the sound processor |

## Verification
The bench walks all 32 host addresses with the enable both high and low, for reads and for writes. A decode that accepted the 4'b1111 group, or that ignored the enable, would drive the bus or raise an interrupt where it should stay silent. Every byte value makes a full round trip through both latches, which exposes a swapped or stuck data bit and a semaphore that a status read clears by mistake. The reset pulse is counted cycle by cycle, both on its own and when retriggered, to catch an off-by-one length or a pulse that disturbs the latches. Simultaneous set and clear on each semaphore checks the set-wins rule. A design that got it wrong would drop the new message's interrupt.

// File: rtl/mbox_pkg.sv
// Package: shared types for the two-way mailbox.
// Assumes: one command channel (host to sound) and one reply channel (sound to host).
package mbox_pkg;

    // Index of each one-byte channel in the channel array.
    localparam int CH_CMD  = 0;
    localparam int CH_RPLY = 1;
    localparam int CH_NUM  = 2;

    // Host address width and the fixed window pattern on bits 4..1.
    localparam int          HOST_AW  = 5;
    localparam logic [3:0]  WIN_PATT = 4'b1110;

    // Decoded host accesses that leave the host port module.
    typedef struct packed {
        logic data_rd;
        logic data_wr;
        logic ctrl_wr;
    } host_acc_t;

endpackage

// File: rtl/mbox_host_port.sv
// Module: host-side window decode and read-data multiplexer.
// Does: turns address, enable and strobes into decoded accesses; builds read
//       data with a per-bit drive enable (bits not driven read as enable 0).
// Assumes: host_rd and host_wr are one clock wide; data is combinational.
module mbox_host_port
    import mbox_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_sel_n,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [DATA_W-1:0]  rply_data,
    input  logic               rply_flag,
    output host_acc_t          acc,
    output logic [DATA_W-1:0]  host_rdata,
    output logic [DATA_W-1:0]  host_rdata_oe
);

    localparam int STAT_BIT = DATA_W - 1;

    logic win_hit;
    logic reg_ctrl;
    logic ctrl_rd;

    // Window match: enable low and bits 4..1 equal the fixed pattern.
    always_comb begin
        win_hit  = !host_sel_n && (host_addr[HOST_AW-1:1] == WIN_PATT);
        reg_ctrl = host_addr[0];
    end

    // Split the window hit into the four register accesses.
    always_comb begin
        acc.data_rd = win_hit && host_rd && !reg_ctrl;
        acc.data_wr = win_hit && host_wr && !reg_ctrl;
        acc.ctrl_wr = win_hit && host_wr &&  reg_ctrl;
        ctrl_rd     = win_hit && host_rd &&  reg_ctrl;
    end

    // Read mux: full byte for data, one status bit for control, else undriven.
    always_comb begin
        host_rdata    = '0;
        host_rdata_oe = '0;
        if (acc.data_rd) begin
            host_rdata    = rply_data;
            host_rdata_oe = '1;
        end else if (ctrl_rd) begin
            host_rdata[STAT_BIT]    = rply_flag;
            host_rdata_oe[STAT_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/mbox_channel.sv
// Module: one byte latch plus its semaphore flip-flop.
// Does: loads the latch and sets the flag on load; clears the flag on clear.
// Assumes: load and clear are one-cycle strobes; load wins over clear so a
//          message arriving while the old one is read is never lost.
module mbox_channel #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clear,
    output logic [DATA_W-1:0] data,
    output logic              flag
);

    // Byte storage, written only by the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= '0;
        else if (load)
            data <= wdata;
    end

    // Semaphore: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (load)
            flag <= 1'b1;
        else if (clear)
            flag <= 1'b0;
    end

endmodule

// File: rtl/mbox_rst_pulse.sv
// Module: fixed-length reset pulse generator for the peer processor.
// Does: a trigger starts (or restarts) a pulse of PULSE_CYC cycles that
//       begins the cycle after the trigger.
// Assumes: PULSE_CYC >= 1.
module mbox_rst_pulse #(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);

    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

    logic [CNT_W-1:0] remain;

    // Down counter of remaining pulse cycles; a trigger reloads it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (trig)
            remain <= CNT_LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    // Pulse is high while cycles remain.
    always_comb pulse = (remain != '0);

endmodule

// File: rtl/mbox_bridge.sv
// Module: two-way byte mailbox between a host bus and a sound-processor bus.
// Does: host writes a command (raises snd_irq_n), sound side reads it (drops
//       the interrupt); sound side writes a reply (raises host_firq_n), host
//       reads it (drops it). A host control write pulses snd_cpu_rst.
// Assumes: all strobes one clock wide; synchronous active-low reset.
module mbox_bridge
    import mbox_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PULSE_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_sel_n,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic [DATA_W-1:0]  host_rdata_oe,
    output logic               host_firq_n,
    input  logic               snd_cmd_rd,
    input  logic               snd_rply_wr,
    input  logic [DATA_W-1:0]  snd_wdata,
    output logic [DATA_W-1:0]  snd_rdata,
    output logic               snd_irq_n,
    output logic               snd_cpu_rst
);

    host_acc_t         acc;
    logic [DATA_W-1:0] ch_wdata [CH_NUM];
    logic [DATA_W-1:0] ch_data  [CH_NUM];
    logic              ch_load  [CH_NUM];
    logic              ch_clear [CH_NUM];
    logic              ch_flag  [CH_NUM];

    // Host window decode and read path.
    mbox_host_port #(.DATA_W(DATA_W)) host_port_i (
        .host_addr     (host_addr),
        .host_sel_n    (host_sel_n),
        .host_rd       (host_rd),
        .host_wr       (host_wr),
        .rply_data     (ch_data[CH_RPLY]),
        .rply_flag     (ch_flag[CH_RPLY]),
        .acc           (acc),
        .host_rdata    (host_rdata),
        .host_rdata_oe (host_rdata_oe)
    );

    // Route strobes and data of each side onto the two channels.
    always_comb begin
        ch_load [CH_CMD]  = acc.data_wr;
        ch_wdata[CH_CMD]  = host_wdata;
        ch_clear[CH_CMD]  = snd_cmd_rd;
        ch_load [CH_RPLY] = snd_rply_wr;
        ch_wdata[CH_RPLY] = snd_wdata;
        ch_clear[CH_RPLY] = acc.data_rd;
    end

    // One latch-plus-semaphore per direction.
    for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
        mbox_channel #(.DATA_W(DATA_W)) ch_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (ch_load[g]),
            .wdata (ch_wdata[g]),
            .clear (ch_clear[g]),
            .data  (ch_data[g]),
            .flag  (ch_flag[g])
        );
    end

    // Peer reset pulse from a host control write.
    mbox_rst_pulse #(.PULSE_CYC(PULSE_CYC)) rst_pulse_i (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (acc.ctrl_wr),
        .pulse (snd_cpu_rst)
    );

    // Active-low interrupt outputs and sound-side read data.
    always_comb begin
        snd_irq_n   = !ch_flag[CH_CMD];
        host_firq_n = !ch_flag[CH_RPLY];
        snd_rdata   = ch_data[CH_CMD];
    end

endmodule

// File: rtl/mbox_bridge_chk.sv
// Module: assertion checker for mbox_bridge, attached with bind.
// Does: relates host/sound strobes to interrupts, pulse and read drive.
// Assumes: observes ports only; the pulse window is measured by a counter.
module mbox_bridge_chk
    import mbox_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PULSE_CYC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HOST_AW-1:0] host_addr,
    input logic               host_sel_n,
    input logic               host_rd,
    input logic               host_wr,
    input logic [DATA_W-1:0]  host_rdata,
    input logic [DATA_W-1:0]  host_rdata_oe,
    input logic               host_firq_n,
    input logic               snd_cmd_rd,
    input logic               snd_rply_wr,
    input logic               snd_irq_n,
    input logic               snd_cpu_rst
);

    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [DATA_W-1:0] STAT_OE = {1'b1, {(DATA_W-1){1'b0}}};

    logic          in_win, cmd_wr, data_rd, ctrl_wr, ctrl_rd;
    logic [CW-1:0] since_trig;

    // Independent view of the host accesses from the ports.
    always_comb begin
        in_win  = !host_sel_n && host_addr[4] && host_addr[3] && host_addr[2] && !host_addr[1];
        cmd_wr  = in_win && host_wr && !host_addr[0];
        data_rd = in_win && host_rd && !host_addr[0];
        ctrl_wr = in_win && host_wr &&  host_addr[0];
        ctrl_rd = in_win && host_rd &&  host_addr[0];
    end

    // Cycles elapsed since the last reset trigger, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_trig <= CW'(PULSE_CYC);
        else if (ctrl_wr)
            since_trig <= '0;
        else if (since_trig < CW'(PULSE_CYC))
            since_trig <= since_trig + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (host_firq_n && snd_irq_n && !snd_cpu_rst)); // R1
    AST_NO_DRIVE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n) !in_win |-> (host_rdata_oe == '0)); // R2
    AST_CMD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n) cmd_wr |=> !snd_irq_n); // R3
    AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (data_rd && !snd_rply_wr) |=> host_firq_n); // R4
    AST_DATA_READ_FULL: assert property (@(posedge clk) disable iff (!rst_n) data_rd |-> (host_rdata_oe == '1)); // R4
    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n) ctrl_wr |=> snd_cpu_rst); // R5
    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) snd_cpu_rst |-> (since_trig < CW'(PULSE_CYC))); // R5
    AST_STATUS_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) ctrl_rd |-> ((host_rdata_oe == STAT_OE) && (host_rdata[DATA_W-1] == !host_firq_n))); // R6
    AST_STATUS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_rd && !data_rd) |=> $stable(host_firq_n)); // R6
    AST_CMD_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (snd_cmd_rd && !cmd_wr) |=> snd_irq_n); // R7
    AST_RPLY_RAISES_FIRQ: assert property (@(posedge clk) disable iff (!rst_n) snd_rply_wr |=> !host_firq_n); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_wr && snd_cmd_rd) |=> !snd_irq_n); // R9

endmodule

bind mbox_bridge mbox_bridge_chk #(.DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)) chk_i (.*);

// File: tb/mbox_bridge_tb_top.sv
// Bench: sweeps the host address space, all byte values and the pulse and
// collision corner cases of mbox_bridge against a model kept in the bench.
module mbox_bridge_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 4;
    localparam logic [4:0] A_DATA = 5'h1C;
    localparam logic [4:0] A_CTRL = 5'h1D;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] host_addr;
    logic       host_sel_n, host_rd, host_wr;
    logic [7:0] host_wdata, host_rdata, host_rdata_oe;
    logic       host_firq_n;
    logic       snd_cmd_rd, snd_rply_wr;
    logic [7:0] snd_wdata, snd_rdata;
    logic       snd_irq_n, snd_cpu_rst;

    int vectors = 0;
    int fails   = 0;

    // Captured combinational outputs during a strobe cycle.
    logic [7:0] cap_hr, cap_oe, cap_sr;

    // Bench model of the mailbox state.
    logic [7:0] m_cmd, m_rep;
    logic       m_cs, m_rs;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_sel_n(host_sel_n),
        .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdata_oe(host_rdata_oe), .host_firq_n(host_firq_n),
        .snd_cmd_rd(snd_cmd_rd), .snd_rply_wr(snd_rply_wr),
        .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
        .snd_irq_n(snd_irq_n), .snd_cpu_rst(snd_cpu_rst)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        host_addr = 5'h00; host_sel_n = 1'b1; host_rd = 1'b0; host_wr = 1'b0;
        host_wdata = 8'h00; snd_cmd_rd = 1'b0; snd_rply_wr = 1'b0; snd_wdata = 8'h00;
    endtask

    // One strobe cycle, entered and left at a falling edge.
    task automatic xfer(input logic [4:0] a, input logic en_n, input logic rd, input logic wr,
                        input logic [7:0] wd, input logic srd, input logic swr, input logic [7:0] swd);
        host_addr = a; host_sel_n = en_n; host_rd = rd; host_wr = wr; host_wdata = wd;
        snd_cmd_rd = srd; snd_rply_wr = swr; snd_wdata = swd;
        #1;
        cap_hr = host_rdata; cap_oe = host_rdata_oe; cap_sr = snd_rdata;
        @(negedge clk);
        idle();
    endtask

    task automatic state_chk(input string req);
        chk(req, "snd_irq_n", {7'd0, snd_irq_n}, {7'd0, !m_cs});
        chk(req, "host_firq_n", {7'd0, host_firq_n}, {7'd0, !m_rs});
        chk(req, "snd_rdata", snd_rdata, m_cmd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        m_cmd = 8'h00; m_rep = 8'h00; m_cs = 1'b0; m_rs = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        state_chk("R1");
        chk("R1", "snd_cpu_rst", {7'd0, snd_cpu_rst}, 8'h00);
        chk("R1", "host_rdata_oe", host_rdata_oe, 8'h00);
        @(negedge clk);

        // R2/R4/R6/R8: read sweep over every address and enable level
        for (int e = 0; e < 2; e++) begin
            for (int a = 0; a < 32; a++) begin
                logic [7:0] v, exp_oe, exp_d;
                logic       hit;
                v = 8'(a * 7 + e * 64 + 3);
                xfer(5'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, v);
                m_rep = v; m_rs = 1'b1;
                chk("R8", "host_firq_n after reply", {7'd0, host_firq_n}, 8'h00);
                hit = (e == 0) && (a[4:1] == 4'b1110);
                exp_oe = !hit ? 8'h00 : (a[0] ? 8'h80 : 8'hFF);
                exp_d  = !hit ? 8'h00 : (a[0] ? {m_rs, 7'd0} : m_rep);
                xfer(5'(a), 1'(e), 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
                chk(hit ? (a[0] ? "R6" : "R4") : "R2", "read oe", cap_oe, exp_oe);
                chk(hit ? (a[0] ? "R6" : "R4") : "R2", "read data", cap_hr & cap_oe, exp_d);
                if (hit && !a[0]) m_rs = 1'b0;
                chk(hit ? (a[0] ? "R6" : "R4") : "R2", "firq after read", {7'd0, host_firq_n}, {7'd0, !m_rs});
            end
        end

        // R2: write sweep outside the window changes nothing
        for (int e = 0; e < 2; e++) begin
            for (int a = 0; a < 32; a++) begin
                if (!((e == 0) && (a[4:1] == 4'b1110))) begin
                    xfer(5'(a), 1'(e), 1'b0, 1'b1, 8'(a ^ 8'h3C), 1'b0, 1'b0, 8'h00);
                    state_chk("R2");
                    chk("R2", "snd_cpu_rst", {7'd0, snd_cpu_rst}, 8'h00);
                end
            end
        end

        // R3/R4/R6/R7/R8: round trip of every byte value
        for (int v = 0; v < 256; v++) begin
            xfer(A_DATA, 1'b0, 1'b0, 1'b1, 8'(v), 1'b0, 1'b0, 8'h00);
            m_cmd = 8'(v); m_cs = 1'b1;
            state_chk("R3");
            xfer(5'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
            chk("R7", "cmd read data", cap_sr, 8'(v));
            m_cs = 1'b0;
            state_chk("R7");
            xfer(5'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, ~8'(v));
            m_rep = ~8'(v); m_rs = 1'b1;
            state_chk("R8");
            xfer(A_CTRL, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
            chk("R6", "status bit", cap_hr & cap_oe, 8'h80);
            state_chk("R6");
            xfer(A_DATA, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
            chk("R4", "reply data", cap_hr, ~8'(v));
            m_rs = 1'b0;
            state_chk("R4");
        end

        // R5: reset pulse length, retrigger, and state preserved
        xfer(A_DATA, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1, 8'hC3);
        m_cmd = 8'h3C; m_cs = 1'b1; m_rep = 8'hC3; m_rs = 1'b1;
        xfer(A_CTRL, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < PULSE + 2; i++) begin
            chk("R5", "pulse", {7'd0, snd_cpu_rst}, {7'd0, 1'(i < PULSE)});
            @(negedge clk);
        end
        state_chk("R5");
        xfer(A_CTRL, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        xfer(A_CTRL, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < PULSE + 2; i++) begin
            chk("R5", "retriggered pulse", {7'd0, snd_cpu_rst}, {7'd0, 1'(i < PULSE)});
            @(negedge clk);
        end
        state_chk("R5");
        xfer(A_DATA, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R5", "reply kept", cap_hr, 8'hC3);
        m_rs = 1'b0;

        // R9: set and clear in the same cycle, both directions
        xfer(A_DATA, 1'b0, 1'b0, 1'b1, 8'h77, 1'b1, 1'b0, 8'h00);
        chk("R9", "cmd read old byte", cap_sr, 8'h3C);
        m_cmd = 8'h77; m_cs = 1'b1;
        state_chk("R9");
        xfer(5'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h99);
        m_rep = 8'h99; m_rs = 1'b1;
        xfer(A_DATA, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'hA6);
        chk("R9", "reply read old byte", cap_hr, 8'h99);
        m_rep = 8'hA6; m_rs = 1'b1;
        state_chk("R9");
        xfer(A_DATA, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R9", "reply new byte", cap_hr, 8'hA6);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule